// File: doc/BRIEF.md
# Segmented SIMD Adder/Subtractor

This block is a 48-bit adder/subtractor whose carry chain can be cut into independent lanes. One operand is built by joining a 30-bit upper input with an 18-bit lower input. The other operand is a 48-bit input. A lane-mode input selects how the 48 bits are used:

- one 48-bit lane,
- two 24-bit lanes, or
- four 12-bit lanes.

A single function code selects addition or subtraction for every lane at once. Each lane reports its own carry (or borrow) on a 4-bit carry vector. The position of each lane's carry bit is fixed by the lane mode.

It is used to pack several narrow additions into one wide datapath. An output register stage is on by default and is controlled by a clock enable and a synchronous reset.

Top module: `simd_addsub`

## Requirements
- R1: The first operand X is {aIn[29:0], bIn[17:0]}, with bIn in the low 18 bits. The second operand Z is cIn[47:0].
- R2: laneMode selects the lane split: 2'b00 gives one 48-bit lane, 2'b01 gives two 24-bit lanes, 2'b10 gives four 12-bit lanes, and 2'b11 behaves as 2'b00. A lane of width w with index i (lane 0 least significant) occupies bits [w*i+w-1 : w*i] of X, Z and pOut.
- R3: opCode 4'b0000 makes every lane compute Z + X modulo 2^w. Any code other than 4'b0011 behaves as 4'b0000.
- R4: opCode 4'b0011 makes every lane compute Z - X modulo 2^w. The lane's carry bit is then the borrow: 1 exactly when X > Z within the lane.
- R5: No carry or borrow crosses a lane boundary. An overflowing lane leaves the result of the next lane unchanged.
- R6: In four-lane mode, carryOut[i] is the carry of lane i, i.e. the 13th result bit of that lane.
- R7: In two-lane mode, carryOut[1] and carryOut[3] hold the carries of lane 0 and lane 1, and carryOut[0] and carryOut[2] are 0.
- R8: In one-lane mode, carryOut[3] holds the 48-bit carry and carryOut[2:0] are 0.
- R9: With the output register present (OUT_REG=1, the default), pOut and carryOut take the result of the inputs sampled at a rising edge where en is 1. They hold their value at edges where en is 0.
- R10: A rising edge with rst high clears pOut and carryOut to 0. rst takes priority over en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Output register load enable |
| laneMode | input | 2 | Lane split select |
| opCode | input | 4 | Add/subtract function code |
| aIn | input | 30 | Upper part of operand X |
| bIn | input | 18 | Lower part of operand X |
| cIn | input | 48 | Operand Z |
| pOut | output | 48 | Lane results |
| carryOut | output | 4 | Per-lane carry or borrow bits |

## Verification
The assertions assume the output register is built in. They also assume laneMode and opCode are known (not X) at every enabled edge, since each check looks back one cycle at those inputs to decide which carry bits must be zero.

The stimulus keeps to this by driving every input to a defined value on the falling edge, holding it across the following rising edge, and releasing rst before any data is loaded. The lane-0 sum property applies only to addition in four-lane mode. The sweeps therefore visit that mode with both narrow values and all-ones values, so the property is exercised with and without a carry.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int SEG_W = 12;
  localparam int SEGS  = 4;
  localparam int DW    = SEG_W * SEGS;
  localparam int AW    = 30;
  localparam int BW    = DW - AW;

  localparam logic [1:0] MODE_ONE  = 2'b00;
  localparam logic [1:0] MODE_TWO  = 2'b01;
  localparam logic [1:0] MODE_FOUR = 2'b10;

  localparam logic [3:0] FN_ADD = 4'b0000;
  localparam logic [3:0] FN_SUB = 4'b0011;

  typedef struct packed {
    logic            sub;
    logic [SEGS-1:0] segStart;
    logic [SEGS-1:0] segReport;
  } ctrl_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic [1:0] laneMode,
  input  logic [3:0] opCode,
  output ctrl_t      ctrl
);
  always_comb begin
    int span;
    case (laneMode)
      MODE_FOUR: span = 1;
      MODE_TWO:  span = SEGS / 2;
      default:   span = SEGS;
    endcase
    ctrl.sub = (opCode == FN_SUB);
    for (int k = 0; k < SEGS; k++) begin
      ctrl.segStart[k]  = ((k % span) == 0);
      ctrl.segReport[k] = ((k % span) == (span - 1));
    end
  end
endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
(
  input  ctrl_t           ctrl,
  input  logic [DW-1:0]   xOp,
  input  logic [DW-1:0]   zOp,
  output logic [DW-1:0]   sum,
  output logic [SEGS-1:0] cy
);
  logic [SEGS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    logic [SEG_W-1:0] xSeg;
    logic [SEG_W-1:0] zSeg;
    logic [SEG_W:0]   segSum;
    logic             cin;

    assign xSeg   = ctrl.sub ? ~xOp[k*SEG_W +: SEG_W] : xOp[k*SEG_W +: SEG_W];
    assign zSeg   = zOp[k*SEG_W +: SEG_W];
    assign cin    = ctrl.segStart[k] ? ctrl.sub : chain[k];
    assign segSum = {1'b0, zSeg} + {1'b0, xSeg} + {{SEG_W{1'b0}}, cin};
    assign chain[k+1] = segSum[SEG_W];
    assign sum[k*SEG_W +: SEG_W] = segSum[SEG_W-1:0];
    assign cy[k] = ctrl.segReport[k] & (segSum[SEG_W] ^ ctrl.sub);
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [1:0]      laneMode,
  input  logic [3:0]      opCode,
  input  logic [AW-1:0]   aIn,
  input  logic [BW-1:0]   bIn,
  input  logic [DW-1:0]   cIn,
  output logic [DW-1:0]   pOut,
  output logic [SEGS-1:0] carryOut
);
  ctrl_t           ctrl;
  logic [DW-1:0]   sumComb;
  logic [SEGS-1:0] cyComb;

  simd_ctrl i_ctrl (
    .laneMode (laneMode),
    .opCode   (opCode),
    .ctrl     (ctrl)
  );

  simd_dp i_dp (
    .ctrl (ctrl),
    .xOp  ({aIn, bIn}),
    .zOp  (cIn),
    .sum  (sumComb),
    .cy   (cyComb)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        pOut     <= '0;
        carryOut <= '0;
      end else if (en) begin
        pOut     <= sumComb;
        carryOut <= cyComb;
      end
    end
  end else begin : g_comb
    assign pOut     = sumComb;
    assign carryOut = cyComb;
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk
  import simd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [1:0]      laneMode,
  input logic [3:0]      opCode,
  input logic [AW-1:0]   aIn,
  input logic [BW-1:0]   bIn,
  input logic [DW-1:0]   cIn,
  input logic [DW-1:0]   pOut,
  input logic [SEGS-1:0] carryOut
);
  if (OUT_REG) begin : g_chk
    // R10
    rst_clear_chk: assert property (@(posedge clk)
      rst |=> (pOut == '0) && (carryOut == '0));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(pOut) && $stable(carryOut));

    // R7
    two_lane_carry_chk: assert property (@(posedge clk) disable iff (rst)
      (en && laneMode == MODE_TWO) |=> (carryOut[0] == 1'b0) && (carryOut[2] == 1'b0));

    // R8
    one_lane_carry_chk: assert property (@(posedge clk) disable iff (rst)
      (en && (laneMode == MODE_ONE || laneMode == 2'b11)) |=> (carryOut[SEGS-2:0] == '0));

    // R6
    lane0_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (en && laneMode == MODE_FOUR && opCode == FN_ADD) |=>
        ({carryOut[0], pOut[SEG_W-1:0]} ==
         ($past({1'b0, bIn[SEG_W-1:0]}) + $past({1'b0, cIn[SEG_W-1:0]}))));
  end
endmodule

bind simd_addsub simd_addsub_chk #(.OUT_REG(OUT_REG)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .laneMode (laneMode),
  .opCode   (opCode),
  .aIn      (aIn),
  .bIn      (bIn),
  .cIn      (cIn),
  .pOut     (pOut),
  .carryOut (carryOut)
);

// File: tb/test_simd_addsub.sv
module test_simd_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  laneMode = 2'b00;
  logic [3:0]  opCode = 4'b0000;
  logic [29:0] aIn = '0;
  logic [17:0] bIn = '0;
  logic [47:0] cIn = '0;
  logic [47:0] pOut;
  logic [3:0]  carryOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_addsub i_simd_addsub (
    .clk(clk), .rst(rst), .en(en), .laneMode(laneMode), .opCode(opCode),
    .aIn(aIn), .bIn(bIn), .cIn(cIn), .pOut(pOut), .carryOut(carryOut)
  );

  function automatic logic [51:0] refCalc(logic [1:0] m, logic [3:0] f,
                                          logic [47:0] x, logic [47:0] z);
    int lanes = (m == 2'b10) ? 4 : (m == 2'b01) ? 2 : 1;
    int w = 48 / lanes;
    logic [48:0] mask = (49'd1 << w) - 49'd1;
    logic [47:0] p = '0;
    logic [3:0] co = '0;
    for (int i = 0; i < lanes; i++) begin
      logic [48:0] xs = ({1'b0, x} >> (i * w)) & mask;
      logic [48:0] zs = ({1'b0, z} >> (i * w)) & mask;
      logic [48:0] r = (f == 4'b0011) ? (zs - xs) : (zs + xs);
      logic [48:0] sh = (r & mask) << (i * w);
      p = p | sh[47:0];
      co[(i + 1) * (4 / lanes) - 1] = r[w];
    end
    return {co, p};
  endfunction

  task automatic check(string tag, logic [51:0] act, logic [51:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual co=%h p=%h expected co=%h p=%h",
               tag, act[51:48], act[47:0], exp[51:48], exp[47:0]);
    end
  endtask

  task automatic apply(logic [1:0] m, logic [3:0] f, logic [47:0] x, logic [47:0] z);
    @(negedge clk);
    laneMode = m; opCode = f; aIn = x[47:18]; bIn = x[17:0]; cIn = z; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic runRef(string tag, logic [1:0] m, logic [3:0] f,
                        logic [47:0] x, logic [47:0] z);
    apply(m, f, x, z);
    check(tag, {carryOut, pOut}, refCalc(m, f, x, z));
  endtask

  initial begin
    logic [51:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset state", {carryOut, pOut}, 52'd0);
    rst = 1'b0;

    // R5 / R6: lane 0 overflows in four-lane add, lane 1 stays zero
    apply(2'b10, 4'b0000, 48'h000_000_000_FFF, 48'h000_000_000_001);
    check("R5 four-lane isolation", {carryOut, pOut}, {4'b0001, 48'h0});
    // R7: lane 0 overflows in two-lane add
    apply(2'b01, 4'b0000, 48'h000000_FFFFFF, 48'h000000_000001);
    check("R7 two-lane carry", {carryOut, pOut}, {4'b0010, 48'h0});
    // R8 / R4: one-lane subtract borrow
    apply(2'b00, 4'b0011, 48'h1, 48'h0);
    check("R8 one-lane borrow", {carryOut, pOut}, {4'b1000, 48'hFFFF_FFFF_FFFF});
    // R4: four-lane subtract, every lane borrows, no borrow leaks
    apply(2'b10, 4'b0011, 48'h001_001_001_001, 48'h000_000_000_000);
    check("R4 four-lane borrow", {carryOut, pOut}, {4'b1111, 48'hFFF_FFF_FFF_FFF});
    // R1: operand packing, bIn low
    apply(2'b00, 4'b0000, 48'h000001_000000 | 48'h3_FFFF, 48'h0);
    check("R1 operand packing", {carryOut, pOut}, {4'b0000, 48'h000001_03FFFF});
    // R2: mode 11 acts as one lane
    apply(2'b11, 4'b0000, 48'hFFFF_FFFF_FFFF, 48'h1);
    check("R2 mode 11 one lane", {carryOut, pOut}, {4'b1000, 48'h0});
    // R3: unlisted code behaves as add
    apply(2'b10, 4'b0101, 48'h005_004_003_002, 48'h001_001_001_001);
    check("R3 other code adds", {carryOut, pOut}, {4'b0000, 48'h006_005_004_003});

    // R9: enable low holds output
    held = {carryOut, pOut};
    @(negedge clk);
    laneMode = 2'b10; opCode = 4'b0000; aIn = '1; bIn = '1; cIn = '1; en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 hold with en low", {carryOut, pOut}, held);

    // R10: reset beats enable
    en = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 reset over enable", {carryOut, pOut}, 52'd0);
    rst = 1'b0; en = 1'b0;

    // sweeps over every mode and function with corner and random data
    for (int m = 0; m < 4; m++) begin
      for (int fi = 0; fi < 3; fi++) begin
        logic [3:0] f = (fi == 0) ? 4'b0000 : (fi == 1) ? 4'b0011 : 4'b1001;
        string tag = (fi == 1) ? "R4 sweep" : "R3 sweep";
        runRef(tag, m[1:0], f, '1, '1);
        runRef(tag, m[1:0], f, '1, 48'h1);
        runRef(tag, m[1:0], f, 48'h800_800_800_800, 48'h800_800_800_800);
        runRef(tag, m[1:0], f, 48'h0, 48'h0);
        for (int n = 0; n < 60; n++) begin
          logic [47:0] x = {$urandom, $urandom};
          logic [47:0] z = {$urandom, $urandom};
          runRef(tag, m[1:0], f, x, z);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule